// File: doc/BRIEF.md
# Digit-Serial Fixed-Point Adder with Run-Time Word Length

This block adds two two's complement fixed-point operands one digit per clock cycle, starting with the least significant digit. The digit width is 8 or 16 bits and is set at build time. Operands may be up to 32 bits wide. A carry register sits between consecutive digits, so a word of N digits takes N cycles on one digit-wide ripple adder.

The number of digits in a word is chosen at run time by a select input. The block samples that input on the first digit of each word. A longer word takes more cycles and gives more precision, and the hardware stays the same. The producer marks the first digit of every word. The block marks the final digit of each word on its output and reports, with that digit, whether the signed sum overflowed the configured word length. Words can follow each other with no idle cycle between them.

A typical use is as the add stage of a serial datapath whose precision a controller lowers or raises between words, depending on how good the results have to be.

Top module: `digit_serial_adder`

## Requirements
- R1: For every accepted digit, `out_valid` is high on the next cycle. On that cycle, `out_digit` holds the low DIGIT_W bits of `a_digit + b_digit + carry-in`.
- R2: A digit with `in_first` high is added with a carry-in of 0, whatever carry the previous word left. This lets words run back to back.
- R3: The carry out of each non-final digit is the carry-in of the next accepted digit of the same word.
- R4: The word length is MIN_WORD_W + `len_sel`*DIGIT_W bits, limited to MAX_WORD_W, and is sent as that many digits. With 8-bit digits, `len_sel` 0/1/2/3 selects 16/24/32/32 bits. With 16-bit digits, `len_sel` 0/1 selects 16/32 bits, so a 16-bit word is one digit.
- R5: `out_last` is high only with the output of the final digit of a word. A one-digit word has `out_last` high on its only output.
- R6: `out_ovf` is high only together with `out_last`. It flags two's complement overflow of the configured word, that is, the carry into the top bit of the final digit differs from the carry out of it.
- R7: `len_sel` is sampled only on a digit with `in_first` high. Changing it in the middle of a word does not change where that word ends.
- R8: A cycle with `in_valid` low, or with `in_valid` high and `in_first` low while no word is open, produces no output (`out_valid` low on the next cycle).
- R9: A digit with `in_first` high that arrives while a word is open drops the open word and starts a new one, with a carry-in of 0 and a new length.
- R10: While `rst_n` is low, `out_valid`, `out_last`, `out_ovf` and `out_digit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input digit pair is present |
| in_first | input | 1 | The present digit pair is the least significant of a new word |
| len_sel | input | SEL_W (2 at default) | Word length select, sampled with `in_first` |
| a_digit | input | DIGIT_W | Digit of operand A |
| b_digit | input | DIGIT_W | Digit of operand B |
| out_valid | output | 1 | A sum digit is present |
| out_digit | output | DIGIT_W | Sum digit |
| out_last | output | 1 | The sum digit is the final one of its word |
| out_ovf | output | 1 | Signed overflow of the word just completed |

## Verification
Some rules hold on every cycle, and the assertions check them: overflow only with the last flag, the last flag only on a valid output, no output after an idle input, an output after every start digit, and a carry-free first digit. The checker also counts the output digits of each word and compares the count with the length it derives from the select value sampled at the start. Only the bench's scenarios show that the sum digits are correct. Those are the carry chains across digit boundaries, the overflow cases at 16, 24 and 32 bits, the clamped select value, a select change mid-word, an abandoned word, and the one-digit word of the 16-bit variant.

// File: rtl/dsadd_pkg.sv
package dsadd_pkg;

   // Number of digits in a word for a given select value, limited to the maximum.
   function automatic int unsigned dsadd_word_digits(int unsigned sel,
                                                     int unsigned min_d,
                                                     int unsigned max_d);
      int unsigned n;
      n = min_d + sel;
      return (n > max_d) ? max_d : n;
   endfunction

   // Width of the word length select input.
   function automatic int unsigned dsadd_sel_w(int unsigned dw,
                                               int unsigned min_w,
                                               int unsigned max_w);
      int unsigned n;
      n = max_w / dw - min_w / dw + 1;
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Width of a digit index counter that can hold the maximum digit count.
   function automatic int unsigned dsadd_cnt_w(int unsigned dw, int unsigned max_w);
      return $clog2(max_w / dw + 1);
   endfunction

endpackage

// File: rtl/dsadd_full_adder.sv
module dsadd_full_adder (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);
   assign s  = x ^ y ^ ci;
   assign co = (x & y) | (ci & (x ^ y));
endmodule

// File: rtl/dsadd_digit_adder.sv
module dsadd_digit_adder #(
   parameter int unsigned DIGIT_W    = 8,
   parameter int unsigned ADDER_IMPL = 0   // 0: chain of full-adder cells, 1: vector add
) (
   input  logic [DIGIT_W-1:0] a,
   input  logic [DIGIT_W-1:0] b,
   input  logic               cin,
   output logic [DIGIT_W-1:0] sum,
   output logic               cout,
   output logic               c_msb   // carry into the top bit
);
   localparam int unsigned MSB = DIGIT_W - 1;

   if (ADDER_IMPL == 0) begin : g_ripple
      logic [DIGIT_W:0] c;
      assign c[0] = cin;
      for (genvar i = 0; i < DIGIT_W; i++) begin : g_bit
         dsadd_full_adder u_fa (
            .x  (a[i]),
            .y  (b[i]),
            .ci (c[i]),
            .s  (sum[i]),
            .co (c[i+1])
         );
      end
      assign cout  = c[DIGIT_W];
      assign c_msb = c[MSB];
   end else begin : g_vector
      logic [DIGIT_W:0] wide;
      assign wide  = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
      assign sum   = wide[MSB:0];
      assign cout  = wide[DIGIT_W];
      assign c_msb = wide[MSB] ^ a[MSB] ^ b[MSB];
   end
endmodule

// File: rtl/dsadd_word_ctrl.sv
module dsadd_word_ctrl #(
   parameter int unsigned SEL_W       = 2,
   parameter int unsigned CNT_W       = 3,
   parameter int unsigned MIN_DIGITS  = 2,
   parameter int unsigned MAX_DIGITS  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_first,
   input  logic [SEL_W-1:0] len_sel,
   output logic             start,    // first digit of a new word
   output logic             accept,   // digit belongs to a word and is processed
   output logic             is_last   // accepted digit is the word's final one
);
   logic             busy_q;
   logic [CNT_W-1:0] idx_q;
   logic [CNT_W-1:0] len_q;
   logic [CNT_W-1:0] idx_cur;
   logic [CNT_W-1:0] len_cur;
   logic             cont;

   assign start   = in_valid & in_first;
   assign cont    = in_valid & ~in_first & busy_q;
   assign accept  = start | cont;
   assign idx_cur = start ? '0 : idx_q;
   assign len_cur = start
                  ? CNT_W'(dsadd_pkg::dsadd_word_digits(32'(len_sel), MIN_DIGITS, MAX_DIGITS))
                  : len_q;
   assign is_last = accept & (idx_cur == len_cur - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         len_q  <= '0;
      end else if (accept) begin
         busy_q <= ~is_last;
         idx_q  <= idx_cur + 1'b1;
         if (start) len_q <= len_cur;
      end
   end
endmodule

// File: rtl/digit_serial_adder.sv
module digit_serial_adder #(
   parameter int unsigned DIGIT_W    = 8,
   parameter int unsigned MAX_WORD_W = 32,
   parameter int unsigned MIN_WORD_W = 16,
   parameter int unsigned ADDER_IMPL = 0,
   localparam int unsigned SEL_W     = dsadd_pkg::dsadd_sel_w(DIGIT_W, MIN_WORD_W, MAX_WORD_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               in_first,
   input  logic [SEL_W-1:0]   len_sel,
   input  logic [DIGIT_W-1:0] a_digit,
   input  logic [DIGIT_W-1:0] b_digit,
   output logic               out_valid,
   output logic [DIGIT_W-1:0] out_digit,
   output logic               out_last,
   output logic               out_ovf
);
   localparam int unsigned MAX_DIGITS = MAX_WORD_W / DIGIT_W;
   localparam int unsigned MIN_DIGITS = MIN_WORD_W / DIGIT_W;
   localparam int unsigned CNT_W      = dsadd_pkg::dsadd_cnt_w(DIGIT_W, MAX_WORD_W);

   // elaboration-time parameter checks
   if (!(DIGIT_W == 8 || DIGIT_W == 16)) begin : g_bad_digit
      $error("digit_serial_adder: DIGIT_W must be 8 or 16");
   end
   if (MAX_WORD_W > 32 || (MAX_WORD_W % DIGIT_W) != 0) begin : g_bad_max
      $error("digit_serial_adder: MAX_WORD_W must be a multiple of DIGIT_W, at most 32");
   end
   if (MIN_WORD_W == 0 || (MIN_WORD_W % DIGIT_W) != 0 || MIN_WORD_W > MAX_WORD_W) begin : g_bad_min
      $error("digit_serial_adder: MIN_WORD_W must be a nonzero multiple of DIGIT_W, not above MAX_WORD_W");
   end
   if (ADDER_IMPL > 1) begin : g_bad_impl
      $error("digit_serial_adder: ADDER_IMPL must be 0 or 1");
   end

   logic               start;
   logic               accept;
   logic               is_last;
   logic               carry_q;
   logic               cin;
   logic [DIGIT_W-1:0] sum;
   logic               cout;
   logic               c_msb;

   dsadd_word_ctrl #(
      .SEL_W      (SEL_W),
      .CNT_W      (CNT_W),
      .MIN_DIGITS (MIN_DIGITS),
      .MAX_DIGITS (MAX_DIGITS)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_first (in_first),
      .len_sel  (len_sel),
      .start    (start),
      .accept   (accept),
      .is_last  (is_last)
   );

   // carry is forced to zero on a word's first digit
   assign cin = start ? 1'b0 : carry_q;

   dsadd_digit_adder #(
      .DIGIT_W    (DIGIT_W),
      .ADDER_IMPL (ADDER_IMPL)
   ) u_add (
      .a     (a_digit),
      .b     (b_digit),
      .cin   (cin),
      .sum   (sum),
      .cout  (cout),
      .c_msb (c_msb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         carry_q   <= 1'b0;
         out_valid <= 1'b0;
         out_digit <= '0;
         out_last  <= 1'b0;
         out_ovf   <= 1'b0;
      end else begin
         out_valid <= accept;
         out_last  <= is_last;
         out_ovf   <= is_last & (c_msb ^ cout);
         if (accept) begin
            carry_q   <= cout;
            out_digit <= sum;
         end
      end
   end
endmodule

// File: rtl/digit_serial_adder_chk.sv
module digit_serial_adder_chk #(
   parameter int unsigned DIGIT_W    = 8,
   parameter int unsigned MAX_WORD_W = 32,
   parameter int unsigned MIN_WORD_W = 16,
   localparam int unsigned SEL_W     = dsadd_pkg::dsadd_sel_w(DIGIT_W, MIN_WORD_W, MAX_WORD_W)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_first,
   input logic [SEL_W-1:0]   len_sel,
   input logic [DIGIT_W-1:0] a_digit,
   input logic [DIGIT_W-1:0] b_digit,
   input logic               out_valid,
   input logic [DIGIT_W-1:0] out_digit,
   input logic               out_last,
   input logic               out_ovf
);
   localparam int unsigned MAX_DIGITS = MAX_WORD_W / DIGIT_W;
   localparam int unsigned MIN_DIGITS = MIN_WORD_W / DIGIT_W;

   logic             first_d;
   logic [SEL_W-1:0] sel_d;
   logic [7:0]       n_q, need_q, n_cur, need_cur;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_d <= 1'b0;
         sel_d   <= '0;
         n_q     <= '0;
         need_q  <= '0;
      end else begin
         first_d <= in_valid & in_first;
         sel_d   <= len_sel;
         if (out_valid) begin
            n_q    <= n_cur;
            need_q <= need_cur;
         end
      end
   end

   always_comb begin
      if (out_valid && first_d) begin
         n_cur    = 8'd1;
         need_cur = 8'(dsadd_pkg::dsadd_word_digits(32'(sel_d), MIN_DIGITS, MAX_DIGITS));
      end else begin
         n_cur    = out_valid ? n_q + 8'd1 : n_q;
         need_cur = need_q;
      end
   end

   AST_START_GIVES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_first) |=> out_valid); // R1
   AST_FIRST_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_first && a_digit == '0 && b_digit == '0) |=> (out_digit == '0)); // R2
   AST_CARRY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && a_digit == '0 && b_digit == '0) |=> (out_digit <= DIGIT_W'(1))); // R3
   AST_WORD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_last) |-> (n_cur == need_cur)); // R4
   AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_last) |-> (n_cur < need_cur)); // R5
   AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n) out_last |-> out_valid); // R5
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) out_ovf |-> out_last); // R6
   AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R8
endmodule

bind digit_serial_adder digit_serial_adder_chk #(
   .DIGIT_W    (DIGIT_W),
   .MAX_WORD_W (MAX_WORD_W),
   .MIN_WORD_W (MIN_WORD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_first  (in_first),
   .len_sel   (len_sel),
   .a_digit   (a_digit),
   .b_digit   (b_digit),
   .out_valid (out_valid),
   .out_digit (out_digit),
   .out_last  (out_last),
   .out_ovf   (out_ovf)
);

// File: tb/digit_serial_adder_tb.sv
`timescale 1ns/1ps
module digit_serial_adder_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   // 8-bit digit instance
   logic       v8 = 0, f8 = 0;
   logic [1:0] s8 = '0;
   logic [7:0] a8 = '0, b8 = '0;
   logic       ov8, ol8, of8;
   logic [7:0] od8;
   // 16-bit digit instance
   logic        v16 = 0, f16 = 0;
   logic [0:0]  s16 = '0;
   logic [15:0] a16 = '0, b16 = '0;
   logic        ov16, ol16, of16;
   logic [15:0] od16;

   digit_serial_adder #(.DIGIT_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_first(f8), .len_sel(s8),
      .a_digit(a8), .b_digit(b8), .out_valid(ov8), .out_digit(od8),
      .out_last(ol8), .out_ovf(of8));

   digit_serial_adder #(.DIGIT_W(16)) u_dut16 (
      .clk(clk), .rst_n(rst_n), .in_valid(v16), .in_first(f16), .len_sel(s16),
      .a_digit(a16), .b_digit(b16), .out_valid(ov16), .out_digit(od16),
      .out_last(ol16), .out_ovf(of16));

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // one cycle of stimulus; returns after the registered outputs have settled
   task automatic step(input bit w, input logic v, input logic f, input logic [1:0] s,
                       input logic [15:0] a, input logic [15:0] b);
      @(negedge clk);
      if (!w) begin
         v8 = v; f8 = f; s8 = s; a8 = a[7:0]; b8 = b[7:0]; v16 = 1'b0;
      end else begin
         v16 = v; f16 = f; s16 = s[0]; a16 = a; b16 = b; v8 = 1'b0;
      end
      @(posedge clk);
      #1;
   endtask

   // drives a whole word; sel on the first digit, sel_mid on the others
   task automatic run_word(input bit w, input logic [1:0] sel, input logic [1:0] sel_mid,
                           input logic [31:0] a, input logic [31:0] b,
                           input logic exp_ovf, input string req);
      int unsigned dw, wl, nd;
      logic [32:0] full;
      dw   = w ? 16 : 8;
      wl   = 16 + int'(sel) * dw;
      if (wl > 32) wl = 32;
      nd   = wl / dw;
      full = {1'b0, a} + {1'b0, b};
      for (int k = 0; k < int'(nd); k++) begin
         logic [31:0] sa, sb, se;
         logic [15:0] mask, got_d;
         logic        got_v, got_l, got_o, el, eo;
         sa   = a >> (k * dw);
         sb   = b >> (k * dw);
         se   = 32'(full >> (k * dw));
         mask = w ? 16'hFFFF : 16'h00FF;
         step(w, 1'b1, (k == 0), (k == 0) ? sel : sel_mid, sa[15:0] & mask, sb[15:0] & mask);
         got_v = w ? ov16 : ov8;
         got_d = w ? od16 : {8'h00, od8};
         got_l = w ? ol16 : ol8;
         got_o = w ? of16 : of8;
         el    = (k == int'(nd) - 1);
         eo    = el & exp_ovf;
         check(got_v && got_d == (se[15:0] & mask) && got_l == el && got_o == eo, req,
               $sformatf("digit %0d {valid,last,ovf,digit}", k),
               {13'd0, got_v, got_l, got_o, got_d}, {13'd0, 1'b1, el, eo, se[15:0] & mask});
      end
   endtask

   // stimulus table for the 8-bit digit instance: select, A, B, expected overflow
   localparam int NV = 8;
   localparam logic [1:0]  VSEL [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd0};
   localparam logic [31:0] VA   [NV] = '{32'h0000_1234, 32'h0000_7FFF, 32'h00FF_00FF, 32'h0080_0000,
                                         32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h1234_5678, 32'hABCD_8000};
   localparam logic [31:0] VB   [NV] = '{32'h0000_1111, 32'h0000_0001, 32'h0000_0F01, 32'h0080_0000,
                                         32'h0000_0001, 32'h7FFF_FFFF, 32'h8765_4321, 32'h1234_8000};
   localparam logic        VOVF [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R1: actual run still going, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      // R10: reset state while held in reset, even with input present
      v8 = 1'b1; f8 = 1'b1; a8 = 8'hFF; b8 = 8'hFF;
      repeat (3) @(posedge clk);
      #1;
      check(!ov8 && !ol8 && !of8 && od8 == 8'h00, "R10", "reset outputs 8-bit",
            {ov8, ol8, of8, od8}, 32'h0);
      check(!ov16 && !ol16 && !of16 && od16 == 16'h0, "R10", "reset outputs 16-bit",
            {ov16, ol16, of16, od16}, 32'h0);
      @(negedge clk);
      v8 = 1'b0; f8 = 1'b0;
      rst_n = 1'b1;

      // R1 R3 R4 R5 R6 R2: table, words issued back to back
      for (int i = 0; i < NV; i++) begin
         run_word(1'b0, VSEL[i], VSEL[i], VA[i], VB[i], VOVF[i], "R1/R3/R4/R6 table");
      end

      // R8: idle cycle and stray digit with no open word give no output
      step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0055, 16'h0011);
      check(!ov8, "R8", "valid after idle", {31'd0, ov8}, 32'd0);
      step(1'b0, 1'b1, 1'b0, 2'd0, 16'h0055, 16'h0011);
      check(!ov8, "R8", "valid after stray digit", {31'd0, ov8}, 32'd0);

      // R7: select raised mid-word, word still ends after 2 digits
      run_word(1'b0, 2'd0, 2'd2, 32'h0000_1234, 32'h0000_4321, 1'b0, "R7 raise");
      // R7: select lowered mid-word, word still runs 4 digits
      run_word(1'b0, 2'd2, 2'd0, 32'h0102_0304, 32'h00FF_00FF, 1'b0, "R7 lower");
      step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0);
      check(!ov8, "R7", "no extra digit expected", {31'd0, ov8}, 32'd0);

      // R9: abandon a 32-bit word after 2 digits that leave a carry
      step(1'b0, 1'b1, 1'b1, 2'd2, 16'h00FF, 16'h00FF);
      check(ov8 && od8 == 8'hFE && !ol8, "R9", "abandoned digit 0", {ov8, ol8, of8, od8},
            {1'b1, 1'b0, 1'b0, 8'hFE});
      step(1'b0, 1'b1, 1'b0, 2'd2, 16'h00FF, 16'h00FF);
      check(ov8 && od8 == 8'hFF && !ol8, "R9", "abandoned digit 1", {ov8, ol8, of8, od8},
            {1'b1, 1'b0, 1'b0, 8'hFF});
      // restart: carry must be cleared (R2) and length now 16 bits
      run_word(1'b0, 2'd0, 2'd0, 32'h0000_0101, 32'h0000_0101, 1'b0, "R9/R2 restart");

      // R4 R5 R6: 16-bit digit variant, one-digit and two-digit words
      run_word(1'b1, 2'd0, 2'd0, 32'h0000_7FFF, 32'h0000_0001, 1'b1, "R5/R6 16-bit one digit");
      run_word(1'b1, 2'd1, 2'd1, 32'h0000_FFFF, 32'h0000_0001, 1'b0, "R3/R4 16-bit carry");
      run_word(1'b1, 2'd1, 2'd1, 32'h8000_0000, 32'h8000_0000, 1'b1, "R6 16-bit negative");
      step(1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0);
      check(!ov16, "R8", "16-bit idle", {31'd0, ov16}, 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule